// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator with Routed Interrupts

This block watches a live calendar time, supplied as packed BCD fields (seconds, minutes, hours, day of month, month), and compares it against a programmed alarm. Software chooses which of the five fields take part in the comparison. When every selected field agrees with the live time, a sticky alarm flag is raised. The flag drives one of two active-low interrupt outputs. Each output can hold its level while the flag stays set, or it can emit a pulse of fixed length.

Software reaches the block through a simple byte-wide register port: a write strobe, an address and write data, plus a combinational read-data path. The flag is cleared by writing a zero to its bit. A pin-mode register chooses which output carries the interrupt; an output that is not selected stays high. The block keeps no time of its own. The counting logic elsewhere supplies the time fields.

Top module: `alarm_irq_unit`

## Requirements
- R1: Register map, read back masked to the implemented bits: 0x08 seconds (bits 6:0), 0x09 minutes (6:0), 0x0A hours (5:0), 0x0B day (5:0), 0x0C month (4:0), 0x10 compare enables (4:0), 0x27 pin modes (bits 7 and 3:0), 0x29 output-A control and 0x2A output-B control (bits 7 and 4), 0x2B flags (bit 5). Every other address reads 0x00.
- R2: Enable bit 0 selects seconds, bit 1 minutes, bit 2 hours, bit 3 day and bit 4 month. The flag (bit 5 of 0x2B) sets on the clock edge at which every enabled field first equals its live counterpart. Fields that are not enabled have no effect on the result.
- R3: With all five enable bits clear, the flag never sets.
- R4: The flag sets only on a rising edge of the match. If the flag is cleared while the match still holds, it stays clear until the match drops and then returns.
- R5: A write to 0x2B with bit 5 at 0 clears the flag, and a write with bit 5 at 1 leaves it unchanged. When a clear write and a new match arrive in the same cycle, the new match wins and the flag stays set.
- R6: Level form (control bit 7 = 1): the routed output is low as long as both the flag and the control's alarm enable (bit 4) are set.
- R7: Pulse form (control bit 7 = 0): when the flag goes from 0 to 1 with the alarm enable set, the routed output is low for exactly PULSE_CYC cycles, starting right after the setting edge.
- R8: Output A carries the interrupt only when bits 1:0 of 0x27 equal 2. Output B carries it only when bits 3:2 equal 1. In any other mode, that output stays high.
- R9: After reset, all registers read zero and both outputs are high.
- R10: The hour compare uses all 6 stored bits, so in 12-hour encoding the PM indicator (bit 5) must match too. For example, 0x12 does not match 0x32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| now_sec | input | 7 | Live seconds, BCD |
| now_min | input | 7 | Live minutes, BCD |
| now_hour | input | 6 | Live hours, BCD (PM in bit 5 in 12-hour form) |
| now_day | input | 6 | Live day of month, BCD |
| now_mon | input | 5 | Live month, BCD |
| irq_a_n | output | 1 | Interrupt output A, active low |
| irq_b_n | output | 1 | Interrupt output B, active low |

## Verification
The bench targets several corner cases. The first is a match that persists after the flag has been cleared: a design that detects the match level would raise the flag again at once. The second is a clear write landing on the same edge as a new match: a design that lets the clear win would lose an alarm. The third is a comparison where the only difference is the PM bit of the hour, which a design comparing only the low hour digits would treat as a match. A disabled field that mismatches must not block the alarm, and an empty enable mask must never raise it. In pulse form, the bench counts the low cycles one by one, so a pulse that is one cycle short or one cycle long is caught.

// File: rtl/alarm_pkg.sv
// Shared constants and types for the alarm comparator.
// Assumes a byte-wide register port and BCD time fields sized to their ranges.
package alarm_pkg;
    localparam int NFLD  = 5;
    localparam int W_SEC = 7;
    localparam int W_MIN = 7;
    localparam int W_HR  = 6;
    localparam int W_DAY = 6;
    localparam int W_MON = 5;

    localparam logic [7:0] AD_SEC   = 8'h08;
    localparam logic [7:0] AD_MIN   = 8'h09;
    localparam logic [7:0] AD_HR    = 8'h0A;
    localparam logic [7:0] AD_DAY   = 8'h0B;
    localparam logic [7:0] AD_MON   = 8'h0C;
    localparam logic [7:0] AD_EN    = 8'h10;
    localparam logic [7:0] AD_PIN   = 8'h27;
    localparam logic [7:0] AD_CTLA  = 8'h29;
    localparam logic [7:0] AD_CTLB  = 8'h2A;
    localparam logic [7:0] AD_FLAGS = 8'h2B;

    localparam int FLAG_BIT = 5;
    localparam int CEN_BIT  = 4;
    localparam int CLVL_BIT = 7;

    localparam logic [1:0] PA_DRIVE = 2'd2;
    localparam logic [1:0] PB_DRIVE = 2'd1;

    typedef struct packed {
        logic [W_SEC-1:0] sec;
        logic [W_MIN-1:0] min;
        logic [W_HR-1:0]  hr;
        logic [W_DAY-1:0] day;
        logic [W_MON-1:0] mon;
    } bcd_time_t;

    typedef struct packed {
        logic level;
        logic en;
    } irq_ctl_t;
endpackage

// File: rtl/alarm_regs.sv
// Register file: alarm fields, compare enables, pin modes, two output
// controls and the sticky flag with write-zero-to-clear.
// Assumes set_evt is a one-cycle strobe from the comparator; set beats clear.
module alarm_regs
    import alarm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [7:0]          addr,
    input  logic [7:0]          wdata,
    input  logic                set_evt,
    output logic [7:0]          rdata,
    output bcd_time_t           alarm,
    output logic [NFLD-1:0]     fld_en,
    output irq_ctl_t            ctl [2],
    output logic [1:0]          pin_a_mode,
    output logic [1:0]          pin_b_mode,
    output logic                flag,
    output logic                flag_rise
);
    logic       clk_off_q;
    logic       flag_q;
    logic       clr_req;

    // decode a clear request: a write to the flags register with the flag bit at 0
    always_comb clr_req = we && (addr == AD_FLAGS) && !wdata[FLAG_BIT];

    // configuration registers, written by byte address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm      <= '0;
            fld_en     <= '0;
            ctl[0]     <= '0;
            ctl[1]     <= '0;
            pin_a_mode <= '0;
            pin_b_mode <= '0;
            clk_off_q  <= 1'b0;
        end else if (we) begin
            case (addr)
                AD_SEC:  alarm.sec <= wdata[W_SEC-1:0];
                AD_MIN:  alarm.min <= wdata[W_MIN-1:0];
                AD_HR:   alarm.hr  <= wdata[W_HR-1:0];
                AD_DAY:  alarm.day <= wdata[W_DAY-1:0];
                AD_MON:  alarm.mon <= wdata[W_MON-1:0];
                AD_EN:   fld_en    <= wdata[NFLD-1:0];
                AD_CTLA: ctl[0]    <= '{level: wdata[CLVL_BIT], en: wdata[CEN_BIT]};
                AD_CTLB: ctl[1]    <= '{level: wdata[CLVL_BIT], en: wdata[CEN_BIT]};
                AD_PIN: begin
                    pin_a_mode <= wdata[1:0];
                    pin_b_mode <= wdata[3:2];
                    clk_off_q  <= wdata[7];
                end
                default: ;
            endcase
        end
    end

    // sticky flag: a new match sets it, a zero write clears it, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (set_evt) flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end

    assign flag      = flag_q;
    assign flag_rise = set_evt && !flag_q;

    // read multiplexer, zero for unmapped addresses
    always_comb begin
        rdata = 8'h00;
        case (addr)
            AD_SEC:   rdata = {{(8-W_SEC){1'b0}}, alarm.sec};
            AD_MIN:   rdata = {{(8-W_MIN){1'b0}}, alarm.min};
            AD_HR:    rdata = {{(8-W_HR){1'b0}},  alarm.hr};
            AD_DAY:   rdata = {{(8-W_DAY){1'b0}}, alarm.day};
            AD_MON:   rdata = {{(8-W_MON){1'b0}}, alarm.mon};
            AD_EN:    rdata = {{(8-NFLD){1'b0}},  fld_en};
            AD_PIN:   rdata = {clk_off_q, 3'b000, pin_b_mode, pin_a_mode};
            AD_CTLA:  rdata = {ctl[0].level, 2'b00, ctl[0].en, 4'h0};
            AD_CTLB:  rdata = {ctl[1].level, 2'b00, ctl[1].en, 4'h0};
            AD_FLAGS: rdata = {2'b00, flag_q, 5'h00};
            default:  rdata = 8'h00;
        endcase
    end

    AST_FLAG_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(set_evt));                         // R2
    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_evt) |=> !flag_q);                        // R5
    AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == AD_FLAGS && wdata[FLAG_BIT] && flag_q) |=> flag_q); // R5
endmodule

// File: rtl/alarm_match.sv
// Masked field comparator with rising-edge detection of the match.
// Assumes time and alarm fields share the same BCD encoding and width.
module alarm_match
    import alarm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  bcd_time_t       alarm,
    input  bcd_time_t       now,
    input  logic [NFLD-1:0] fld_en,
    output logic            set_evt
);
    logic [NFLD-1:0] eq;
    logic            match;
    logic            match_q;

    // per-field equality, bit order sec, min, hour, day, month
    always_comb begin
        eq[0] = (alarm.sec == now.sec);
        eq[1] = (alarm.min == now.min);
        eq[2] = (alarm.hr  == now.hr);
        eq[3] = (alarm.day == now.day);
        eq[4] = (alarm.mon == now.mon);
    end

    // overall match: at least one field enabled and all enabled fields equal
    always_comb match = (|fld_en) && (&(eq | ~fld_en));

    // remember last match to find its rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match;
    end

    assign set_evt = match && !match_q;

    AST_NONE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_en == '0) |-> !set_evt);                              // R3
    AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> !set_evt);                                     // R4
endmodule

// File: rtl/alarm_irq_drv.sv
// One interrupt output: level form follows flag and enable, pulse form
// counts PULSE_CYC cycles from a flag rise. Active low, gated by routing.
// Assumes trig is a one-cycle strobe coincident with the flag setting edge.
module alarm_irq_drv
    import alarm_pkg::*;
#(
    parameter int PULSE_CYC = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  irq_ctl_t ctl,
    input  logic     routed,
    input  logic     flag,
    input  logic     trig,
    output logic     irq_n
);
    localparam int CW = $clog2(PULSE_CYC + 1);

    logic [CW-1:0] cnt;
    logic          active;

    // pulse counter: load on a qualified trigger, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (trig && ctl.en && !ctl.level && routed)
            cnt <= CW'(PULSE_CYC);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // select the form of the request
    always_comb active = ctl.level ? (flag && ctl.en) : (cnt != '0);

    assign irq_n = !(routed && active);

    AST_PULSE_FROM_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(irq_n) && !ctl.level && $past(!ctl.level)) |-> $past(trig)); // R7
    AST_UNROUTED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !routed |-> irq_n);                                        // R8
endmodule

// File: rtl/alarm_irq_unit.sv
// Top: register file, masked comparator and two routed interrupt drivers.
// Assumes the live time inputs are synchronous to clk.
module alarm_irq_unit
    import alarm_pkg::*;
#(
    parameter int PULSE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [7:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [W_SEC-1:0] now_sec,
    input  logic [W_MIN-1:0] now_min,
    input  logic [W_HR-1:0]  now_hour,
    input  logic [W_DAY-1:0] now_day,
    input  logic [W_MON-1:0] now_mon,
    output logic             irq_a_n,
    output logic             irq_b_n
);
    localparam int NOUT = 2;

    bcd_time_t       alarm;
    bcd_time_t       now;
    logic [NFLD-1:0] fld_en;
    irq_ctl_t        ctl [NOUT];
    logic [1:0]      pin_a_mode;
    logic [1:0]      pin_b_mode;
    logic            flag;
    logic            flag_rise;
    logic            set_evt;
    logic [NOUT-1:0] routed;
    logic [NOUT-1:0] irq_vec_n;

    // gather the live time into one record
    always_comb now = '{sec: now_sec, min: now_min, hr: now_hour,
                        day: now_day, mon: now_mon};

    // pin routing decode
    always_comb begin
        routed[0] = (pin_a_mode == PA_DRIVE);
        routed[1] = (pin_b_mode == PB_DRIVE);
    end

    alarm_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .set_evt    (set_evt),
        .rdata      (reg_rdata),
        .alarm      (alarm),
        .fld_en     (fld_en),
        .ctl        (ctl),
        .pin_a_mode (pin_a_mode),
        .pin_b_mode (pin_b_mode),
        .flag       (flag),
        .flag_rise  (flag_rise)
    );

    alarm_match u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .alarm   (alarm),
        .now     (now),
        .fld_en  (fld_en),
        .set_evt (set_evt)
    );

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        alarm_irq_drv #(.PULSE_CYC(PULSE_CYC)) u_drv (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctl    (ctl[g]),
            .routed (routed[g]),
            .flag   (flag),
            .trig   (flag_rise),
            .irq_n  (irq_vec_n[g])
        );
    end

    assign irq_a_n = irq_vec_n[0];
    assign irq_b_n = irq_vec_n[1];

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (irq_a_n && irq_b_n));                          // R9
endmodule

// File: tb/alarm_irq_unit_tb.sv
module alarm_irq_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PCYC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [6:0] now_sec = '0;
    logic [6:0] now_min = '0;
    logic [5:0] now_hour = '0;
    logic [5:0] now_day = '0;
    logic [4:0] now_mon = '0;
    logic       irq_a_n, irq_b_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_irq_unit #(.PULSE_CYC(PCYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_day(now_day), .now_mon(now_mon),
        .irq_a_n(irq_a_n), .irq_b_n(irq_b_n));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    // expected flag: some field enabled and every enabled field unperturbed
    function automatic bit exp_match(input logic [4:0] en, input logic [4:0] diff);
        return (en != 0) && ((en & diff) == 0);
    endfunction

    task automatic set_now(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                           input logic [7:0] d, input logic [7:0] mo);
        now_sec = s[6:0]; now_min = m[6:0]; now_hour = h[5:0];
        now_day = d[5:0]; now_mon = mo[4:0];
    endtask

    task automatic load_alarm(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                              input logic [7:0] d, input logic [7:0] mo);
        wr(8'h08, s); wr(8'h09, m); wr(8'h0A, h); wr(8'h0B, d); wr(8'h0C, mo);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        void'($urandom(32'h5EED_1234));
        step(3);
        rst_n = 1'b1;
        step(1);
        // R9 reset state
        chk("R9 irq_a", irq_a_n, 1);
        chk("R9 irq_b", irq_b_n, 1);
        rd(8'h2B, r); chk("R9 flags", r, 0);
        rd(8'h10, r); chk("R9 enables", r, 0);
        rd(8'h29, r); chk("R9 ctl A", r, 0);

        // R1 masking and unmapped reads
        load_alarm(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        rd(8'h08, r); chk("R1 sec", r, 8'h7F);
        rd(8'h0A, r); chk("R1 hour", r, 8'h3F);
        rd(8'h0C, r); chk("R1 month", r, 8'h1F);
        wr(8'h29, 8'hFF); rd(8'h29, r); chk("R1 ctl A", r, 8'h90);
        wr(8'h27, 8'hFF); rd(8'h27, r); chk("R1 pin", r, 8'h8F);
        wr(8'h10, 8'hFF); rd(8'h10, r); chk("R1 enables", r, 8'h1F);
        rd(8'h11, r); chk("R1 unmapped", r, 8'h00);
        wr(8'h10, 8'h00);

        // R3 empty mask never sets even with full equality
        load_alarm(8'h56, 8'h34, 8'h12, 8'h15, 8'h06);
        set_now(8'h56, 8'h34, 8'h12, 8'h15, 8'h06);
        step(3);
        rd(8'h2B, r); chk("R3 no enables", r, 0);

        // R2 R6 level interrupt on output A
        wr(8'h27, 8'h02); wr(8'h29, 8'h90); wr(8'h2A, 8'h00);
        wr(8'h10, 8'h1F);
        chk("R2 not before set edge", irq_a_n, 1);
        step(1);
        rd(8'h2B, r); chk("R2 flag set", r, 8'h20);
        chk("R6 level low", irq_a_n, 0);
        chk("R8 B unrouted", irq_b_n, 1);

        // R5 write one keeps, write zero clears; R4 persisting match no reset
        wr(8'h2B, 8'hFF); rd(8'h2B, r); chk("R5 write one keeps", r, 8'h20);
        wr(8'h2B, 8'hDF); step(2);
        rd(8'h2B, r); chk("R4 no reset while match held", r, 0);
        chk("R6 released", irq_a_n, 1);

        // R4 match drops and returns
        now_sec = 7'h57; step(2);
        now_sec = 7'h56; step(1);
        rd(8'h2B, r); chk("R4 re-arm", r, 8'h20);

        // R8 routing
        wr(8'h27, 8'h03); chk("R8 A high-Z mode", irq_a_n, 1);
        wr(8'h2A, 8'h90); wr(8'h27, 8'h04);
        chk("R8 B routed", irq_b_n, 0);
        chk("R8 A mode 0", irq_a_n, 1);

        // R7 pulse on output B
        wr(8'h2A, 8'h10);
        now_sec = 7'h57; step(1);
        wr(8'h2B, 8'h00);
        chk("R7 idle before", irq_b_n, 1);
        now_sec = 7'h56; step(1);
        for (int k = 0; k < PCYC; k++) begin
            chk("R7 pulse low", irq_b_n, 0);
            step(1);
        end
        chk("R7 pulse ends", irq_b_n, 1);

        // R5 set wins over simultaneous clear
        now_sec = 7'h57; step(1);
        wr(8'h2B, 8'h00);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'h2B; reg_wdata = 8'h00; now_sec = 7'h56;
        @(negedge clk);
        reg_we = 1'b0;
        rd(8'h2B, r); chk("R5 set beats clear", r, 8'h20);

        // R10 PM bit in the hour compare
        wr(8'h10, 8'h00); wr(8'h2B, 8'h00);
        wr(8'h0A, 8'h32); now_hour = 6'h12;
        wr(8'h10, 8'h04); step(2);
        rd(8'h2B, r); chk("R10 AM vs PM", r, 0);
        now_hour = 6'h32; step(1);
        rd(8'h2B, r); chk("R10 PM match", r, 8'h20);

        // R2 random alarms, random masks, random perturbed fields
        for (int it = 0; it < 60; it++) begin
            logic [7:0] s, m, h, d, mo;
            logic [4:0] en, diff;
            s = bcd($urandom_range(0, 59)); m = bcd($urandom_range(0, 59));
            h = bcd($urandom_range(0, 23)); d = bcd($urandom_range(1, 31));
            mo = bcd($urandom_range(1, 12));
            en = 5'($urandom); diff = 5'($urandom);
            if (it % 10 == 0) en = 5'h00;
            wr(8'h10, 8'h00); wr(8'h2B, 8'h00);
            load_alarm(s, m, h, d, mo);
            set_now(s ^ {7'h0, diff[0]}, m ^ {7'h0, diff[1]}, h ^ {7'h0, diff[2]},
                    d ^ {7'h0, diff[3]}, mo ^ {7'h0, diff[4]});
            wr(8'h10, {3'b000, en});
            step(1);
            rd(8'h2B, r);
            chk("R2 random compare", r, exp_match(en, diff) ? 8'h20 : 8'h00);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule